// File: doc/BRIEF.md
# Exposed internal register execute datapath

This block is the execute half of a two-stage processor whose 64-bit instruction word is a bundle of independent effect fields. Each field steers one piece of the datapath in the same cycle. There are no pipeline registers, forwarding paths or hazard checks. Nine software-visible internal registers take their place, and they keep their contents until an effect names them again:

- two register-file read latches (`rda`, `rdb`)
- a load latch (`ldv`)
- a sign-extend latch (`sxt`)
- an ALU result latch (`res`)
- a PC-relative target latch (`tgt`)
- a next-sequential latch (`nxt`)
- two copy registers (`cpa`, `cpb`)

Fetch supplies the word and its PC. The block owns a 32 x 32 general register file and drives a simple data memory port. The memory returns load data in the same cycle, and the memory captures stores at the clock edge.

Any mix of effects may share one word. Every effect reads internal-register and register-file values as they stood at the start of the cycle. All results commit together at the edge.

Top module: `xreg_exec`

## Requirements
- R1: After reset, all internal registers and every register-file entry read as zero.
- R2: Bit 0 enables the first read and bits 5:1 give its index; bit 6 enables the second read and bits 11:7 give its index. Each enabled read loads `rda` or `rdb` from the register file, and index 0 always yields zero.
- R3: Bit 12 enables a register-file write. Bits 17:13 give the destination and bits 21:18 give the internal-register source selector. A write to index 0, or with bit 12 clear, changes nothing.
- R4: Bit 22 loads `sxt` with the 12-bit immediate in bits 34:23, sign-extended to 32 bits.
- R5: Bits 38:35 give the ALU operation: 0 none, 1 add, 2 sub, 3 and, 4 or, 5 xor, 6 not-equal, 7 equal, 8 signed less-than, with others none. Bits 42:39 select operand A and bits 46:43 select operand B. Comparisons yield 1 or 0.
- R6: Operand selectors and all source selectors use these codes: 0 `rda`, 1 `rdb`, 2 `ldv`, 3 `sxt`, 4 `res`, 5 `tgt`, 6 `nxt`, 7 `cpa`, 8 `cpb`, 9 the PC, and other codes zero. When either ALU operand selects the PC, the result goes to `tgt` and `res` keeps its value.
- R7: Bits 48:47 hold the memory operation: 0 none, 1 load, 2 store. The address is the internal register selected by bits 52:49, used with no offset. A load writes the returned data into `ldv`.
- R8: A store drives the write strobe with the address above and with write data from the internal register selected by bits 56:53. No strobe appears without a store.
- R9: Bit 57 enables a copy. Bit 58 picks the destination (0 `cpa`, 1 `cpb`) and bits 62:59 select the source; the other copy register is unchanged.
- R10: Bit 63 loads `nxt` with the PC plus 8.
- R11: An internal register that no effect names keeps its value.
- R12: Every effect in one word observes the values from the start of the cycle, so a load or store in the same word as the effect that rewrites its address source uses the old value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr | input | 64 | Effect word executed this cycle |
| pc | input | 32 | Address of the word in `instr` |
| mem_re | output | 1 | Load request this cycle |
| mem_we | output | 1 | Store strobe this cycle |
| mem_addr | output | 32 | Data memory address |
| mem_wdata | output | 32 | Store data |
| mem_rdata | input | 32 | Load data returned in the same cycle |

## Verification
On every cycle the assertions check these behaviours:

- a read of index 0 leaves zero in its latch
- a load captures the returned word
- a PC-operand ALU effect leaves `res` untouched
- the next-sequential latch tracks the PC
- a copy leaves the other copy register alone
- an idle second read port holds its latch

Some behaviours only the bench's scenarios can show, because they need values to travel through several registers and come out through a store. These are:

- the ALU function results and the sign extension
- register-file writes, including the writes to index 0 that are ignored
- the start-of-cycle visibility between effects that share one word

// File: rtl/xreg_pkg.sv
package xreg_pkg;
   localparam int IW    = 64;
   localparam int IDXW  = 5;
   localparam int SELW  = 4;
   localparam int IMMW  = 12;

   // effect field positions in the instruction word
   localparam int F_RA_EN  = 0;
   localparam int F_RA_IX  = 1;
   localparam int F_RB_EN  = 6;
   localparam int F_RB_IX  = 7;
   localparam int F_WR_EN  = 12;
   localparam int F_WR_IX  = 13;
   localparam int F_WR_SRC = 18;
   localparam int F_SX_EN  = 22;
   localparam int F_IMM    = 23;
   localparam int F_ALU_OP = 35;
   localparam int F_ALU_A  = 39;
   localparam int F_ALU_B  = 43;
   localparam int F_MEM_OP = 47;
   localparam int F_MEM_AD = 49;
   localparam int F_MEM_DA = 53;
   localparam int F_CP_EN  = 57;
   localparam int F_CP_DST = 58;
   localparam int F_CP_SRC = 59;
   localparam int F_SQ_EN  = 63;

   typedef enum logic [SELW-1:0] {
      SEL_RDA = 4'd0, SEL_RDB = 4'd1, SEL_LDV = 4'd2, SEL_SXT = 4'd3,
      SEL_RES = 4'd4, SEL_TGT = 4'd5, SEL_NXT = 4'd6, SEL_CPA = 4'd7,
      SEL_CPB = 4'd8, SEL_PC  = 4'd9
   } src_sel_e;

   typedef enum logic [3:0] {
      OP_NONE = 4'd0, OP_ADD = 4'd1, OP_SUB = 4'd2, OP_AND = 4'd3,
      OP_OR   = 4'd4, OP_XOR = 4'd5, OP_NE  = 4'd6, OP_EQ  = 4'd7,
      OP_LT   = 4'd8
   } alu_op_e;

   typedef enum logic [1:0] {
      MEM_NONE = 2'd0, MEM_LOAD = 2'd1, MEM_STORE = 2'd2
   } mem_op_e;
endpackage

// File: rtl/xreg_rf.sv
module xreg_rf #(
   parameter int XLEN = 32,
   parameter int NREG = 32,
   localparam int IXW = $clog2(NREG)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [IXW-1:0]  ra_ix,
   input  logic [IXW-1:0]  rb_ix,
   output logic [XLEN-1:0] ra_data,
   output logic [XLEN-1:0] rb_data,
   input  logic            wr_en,
   input  logic [IXW-1:0]  wr_ix,
   input  logic [XLEN-1:0] wr_data
);
   logic [XLEN-1:0] ent [NREG];

   for (genvar g = 0; g < NREG; g++) begin : g_ent
      if (g == 0) begin : g_zero
         assign ent[g] = '0;
      end else begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               ent[g] <= '0;
            else if (wr_en && (wr_ix == IXW'(g)))
               ent[g] <= wr_data;
         end
      end
   end

   assign ra_data = ent[ra_ix];
   assign rb_data = ent[rb_ix];
endmodule

// File: rtl/xreg_alu.sv
module xreg_alu
   import xreg_pkg::*;
#(
   parameter int XLEN      = 32,
   parameter bit SIGNED_LT = 1'b1
) (
   input  logic [3:0]      op,
   input  logic [XLEN-1:0] a,
   input  logic [XLEN-1:0] b,
   output logic [XLEN-1:0] y,
   output logic            active
);
   logic lt;

   if (SIGNED_LT) begin : g_slt
      assign lt = $signed(a) < $signed(b);
   end else begin : g_ult
      assign lt = a < b;
   end

   always_comb begin
      active = 1'b1;
      unique case (op)
         OP_ADD:  y = a + b;
         OP_SUB:  y = a - b;
         OP_AND:  y = a & b;
         OP_OR:   y = a | b;
         OP_XOR:  y = a ^ b;
         OP_NE:   y = XLEN'(a != b);
         OP_EQ:   y = XLEN'(a == b);
         OP_LT:   y = XLEN'(lt);
         default: begin
            y      = '0;
            active = 1'b0;
         end
      endcase
   end
endmodule

// File: rtl/xreg_exec.sv
module xreg_exec
   import xreg_pkg::*;
#(
   parameter int XLEN      = 32,
   parameter int NREG      = 32,
   parameter bit SIGNED_LT = 1'b1,
   localparam int STEP     = IW / 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [IW-1:0]   instr,
   input  logic [XLEN-1:0] pc,
   output logic            mem_re,
   output logic            mem_we,
   output logic [XLEN-1:0] mem_addr,
   output logic [XLEN-1:0] mem_wdata,
   input  logic [XLEN-1:0] mem_rdata
);
   if (XLEN < IMMW + 4) begin : g_bad_xlen
      $error("XLEN too small for the immediate field");
   end
   if (NREG != (1 << IDXW)) begin : g_bad_nreg
      $error("NREG must match the register index field");
   end

   // decoded effect fields
   logic            ra_en, rb_en, wr_en, sx_en, cp_en, cp_dst, sq_en;
   logic [IDXW-1:0] ra_ix, rb_ix, wr_ix;
   logic [SELW-1:0] wr_src, alu_a, alu_b, mem_ad, mem_da, cp_src;
   logic [IMMW-1:0] imm;
   logic [3:0]      alu_op;
   logic [1:0]      mem_op;

   assign ra_en  = instr[F_RA_EN];
   assign ra_ix  = instr[F_RA_IX +: IDXW];
   assign rb_en  = instr[F_RB_EN];
   assign rb_ix  = instr[F_RB_IX +: IDXW];
   assign wr_en  = instr[F_WR_EN];
   assign wr_ix  = instr[F_WR_IX +: IDXW];
   assign wr_src = instr[F_WR_SRC +: SELW];
   assign sx_en  = instr[F_SX_EN];
   assign imm    = instr[F_IMM +: IMMW];
   assign alu_op = instr[F_ALU_OP +: 4];
   assign alu_a  = instr[F_ALU_A +: SELW];
   assign alu_b  = instr[F_ALU_B +: SELW];
   assign mem_op = instr[F_MEM_OP +: 2];
   assign mem_ad = instr[F_MEM_AD +: SELW];
   assign mem_da = instr[F_MEM_DA +: SELW];
   assign cp_en  = instr[F_CP_EN];
   assign cp_dst = instr[F_CP_DST];
   assign cp_src = instr[F_CP_SRC +: SELW];
   assign sq_en  = instr[F_SQ_EN];

   // exposed internal registers
   logic [XLEN-1:0] rda_q, rdb_q, ldv_q, sxt_q, res_q, tgt_q, nxt_q, cpa_q, cpb_q;

   function automatic logic [XLEN-1:0] pick(input logic [SELW-1:0] s);
      case (s)
         SEL_RDA: pick = rda_q;
         SEL_RDB: pick = rdb_q;
         SEL_LDV: pick = ldv_q;
         SEL_SXT: pick = sxt_q;
         SEL_RES: pick = res_q;
         SEL_TGT: pick = tgt_q;
         SEL_NXT: pick = nxt_q;
         SEL_CPA: pick = cpa_q;
         SEL_CPB: pick = cpb_q;
         SEL_PC:  pick = pc;
         default: pick = '0;
      endcase
   endfunction

   logic [XLEN-1:0] ra_data, rb_data, alu_y;
   logic            alu_act, pc_used;

   xreg_rf #(.XLEN(XLEN), .NREG(NREG)) u_rf (
      .clk     (clk),
      .rst_n   (rst_n),
      .ra_ix   (ra_ix),
      .rb_ix   (rb_ix),
      .ra_data (ra_data),
      .rb_data (rb_data),
      .wr_en   (wr_en),
      .wr_ix   (wr_ix),
      .wr_data (pick(wr_src))
   );

   xreg_alu #(.XLEN(XLEN), .SIGNED_LT(SIGNED_LT)) u_alu (
      .op     (alu_op),
      .a      (pick(alu_a)),
      .b      (pick(alu_b)),
      .y      (alu_y),
      .active (alu_act)
   );

   assign pc_used   = (alu_a == SEL_PC) || (alu_b == SEL_PC);
   assign mem_re    = (mem_op == MEM_LOAD);
   assign mem_we    = (mem_op == MEM_STORE);
   assign mem_addr  = pick(mem_ad);
   assign mem_wdata = pick(mem_da);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rda_q <= '0; rdb_q <= '0; ldv_q <= '0;
         sxt_q <= '0; res_q <= '0; tgt_q <= '0;
         nxt_q <= '0; cpa_q <= '0; cpb_q <= '0;
      end else begin
         if (ra_en)  rda_q <= ra_data;
         if (rb_en)  rdb_q <= rb_data;
         if (mem_re) ldv_q <= mem_rdata;
         if (sx_en)  sxt_q <= {{(XLEN-IMMW){imm[IMMW-1]}}, imm};
         if (alu_act && pc_used)  tgt_q <= alu_y;
         if (alu_act && !pc_used) res_q <= alu_y;
         if (sq_en)  nxt_q <= pc + XLEN'(STEP);
         if (cp_en && !cp_dst) cpa_q <= pick(cp_src);
         if (cp_en &&  cp_dst) cpb_q <= pick(cp_src);
      end
   end
endmodule

// File: rtl/xreg_exec_chk.sv
module xreg_exec_chk #(
   parameter int XLEN = 32
) (
   input logic            clk,
   input logic            rst_n,
   input logic [63:0]     instr,
   input logic [XLEN-1:0] pc,
   input logic            mem_re,
   input logic [XLEN-1:0] mem_rdata,
   input logic            alu_act,
   input logic            pc_used,
   input logic [XLEN-1:0] rda_q,
   input logic [XLEN-1:0] rdb_q,
   input logic [XLEN-1:0] ldv_q,
   input logic [XLEN-1:0] res_q,
   input logic [XLEN-1:0] nxt_q,
   input logic [XLEN-1:0] cpb_q
);
   p_rd_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (instr[0] && instr[5:1] == 5'd0) |=> (rda_q == '0));

   p_ld_capture_r7: assert property (@(posedge clk) disable iff (!rst_n)
      mem_re |=> (ldv_q == $past(mem_rdata)));

   p_pc_keeps_res_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (alu_act && pc_used) |=> $stable(res_q));

   p_seq_next_r10: assert property (@(posedge clk) disable iff (!rst_n)
      instr[63] |=> (nxt_q == $past(pc) + XLEN'(8)));

   p_copy_other_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (instr[57] && !instr[58]) |=> $stable(cpb_q));

   p_idle_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !instr[6] |=> $stable(rdb_q));
endmodule

bind xreg_exec xreg_exec_chk #(.XLEN(XLEN)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .instr     (instr),
   .pc        (pc),
   .mem_re    (mem_re),
   .mem_rdata (mem_rdata),
   .alu_act   (alu_act),
   .pc_used   (pc_used),
   .rda_q     (rda_q),
   .rdb_q     (rdb_q),
   .ldv_q     (ldv_q),
   .res_q     (res_q),
   .nxt_q     (nxt_q),
   .cpb_q     (cpb_q)
);

// File: tb/xreg_exec_tb.sv
module xreg_exec_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [63:0] instr = '0;
   logic [31:0] pc = '0;
   logic        mem_re, mem_we;
   logic [31:0] mem_addr, mem_wdata, mem_rdata;

   int n_chk = 0;
   int n_bad = 0;
   int step  = 0;
   logic [63:0] q_exp [$];
   string       q_tag [$];

   always #10 clk = ~clk;  // 50 MHz

   // memory model: load data is a fixed function of the address
   assign mem_rdata = ~mem_addr;

   xreg_exec u_dut (
      .clk(clk), .rst_n(rst_n), .instr(instr), .pc(pc),
      .mem_re(mem_re), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
   );

   function automatic logic [63:0] rdA(input int ix);  return 64'(1) | 64'(ix) << 1; endfunction
   function automatic logic [63:0] rdB(input int ix);  return 64'(1) << 6 | 64'(ix) << 7; endfunction
   function automatic logic [63:0] wr(input int ix, input int s);
      return 64'(1) << 12 | 64'(ix) << 13 | 64'(s) << 18;
   endfunction
   function automatic logic [63:0] sx(input int v);    return 64'(1) << 22 | 64'(v & 12'hfff) << 23; endfunction
   function automatic logic [63:0] alu(input int op, input int a, input int b);
      return 64'(op) << 35 | 64'(a) << 39 | 64'(b) << 43;
   endfunction
   function automatic logic [63:0] ld(input int a);    return 64'(1) << 47 | 64'(a) << 49; endfunction
   function automatic logic [63:0] st(input int a, input int d);
      return 64'(2) << 47 | 64'(a) << 49 | 64'(d) << 53;
   endfunction
   function automatic logic [63:0] cp(input int dst, input int s);
      return 64'(1) << 57 | 64'(dst) << 58 | 64'(s) << 59;
   endfunction
   localparam logic [63:0] SQ = 64'(1) << 63;

   // driver: apply one word, push the expected store if any
   task automatic issue(input logic [63:0] w, input bit has_st,
                        input logic [31:0] ea, input logic [31:0] ed, input string tag);
      @(negedge clk);
      instr = w;
      pc    = 32'h100 + 32'(step) * 8;
      step++;
      if (has_st) begin
         q_exp.push_back({ea, ed});
         q_tag.push_back(tag);
      end
   endtask

   // monitor: compare stores a quarter period after each word is applied
   initial forever begin
      @(negedge clk);
      #5;
      if (rst_n) begin
         if (mem_we) begin
            n_chk++;
            if (q_exp.size() == 0) begin
               n_bad++;
               $display("FAIL R8 unexpected store addr=%h data=%h expected none", mem_addr, mem_wdata);
            end else begin
               logic [63:0] e;
               string t;
               e = q_exp.pop_front();
               t = q_tag.pop_front();
               if ({mem_addr, mem_wdata} !== e) begin
                  n_bad++;
                  $display("FAIL %s store got %h/%h expected %h/%h", t, mem_addr, mem_wdata, e[63:32], e[31:0]);
               end
            end
         end else if (q_exp.size() != 0) begin
            n_chk++;
            n_bad++;
            $display("FAIL %s missing store, got none expected %h", q_tag[0], q_exp[0]);
            void'(q_exp.pop_front());
            void'(q_tag.pop_front());
         end
      end
   end

   bit done = 0;
   initial begin
      #4_000_000;
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog expired, got hang expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      logic [31:0] p18, p20;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      issue(st(0, 8), 1, 32'h0, 32'h0, "R1 rda/cpb");
      issue(st(5, 6), 1, 32'h0, 32'h0, "R1 tgt/nxt");
      // R4 R12 sign extend while load uses old sxt
      issue(sx(12'hffc) | ld(3), 0, 0, 0, "");
      issue(st(3, 2), 1, 32'hffff_fffc, 32'hffff_ffff, "R4 R12 sxt/ldv");
      // R3 R12 RF write from old ldv while reloading
      issue(ld(3) | wr(5, 2), 0, 0, 0, "");
      issue(wr(6, 2), 0, 0, 0, "");
      issue(wr(0, 2) | rdA(5) | rdB(6), 0, 0, 0, "");
      issue(st(0, 1), 1, 32'hffff_ffff, 32'h3, "R2 R3 reads");
      issue(rdA(0) | rdB(6) | (wr(9, 2) & ~(64'(1) << 12)), 0, 0, 0, "");
      issue(st(1, 0), 1, 32'h3, 32'h0, "R2 R3 zero index");
      issue(rdA(9), 0, 0, 0, "");
      issue(st(1, 0), 1, 32'h3, 32'h0, "R3 write disabled");
      // R5 ALU (rda=0 rdb=3 ldv=3 sxt=fffffffc)
      issue(alu(1, 2, 3), 0, 0, 0, "");
      issue(st(4, 4) | alu(2, 3, 1), 1, 32'hffff_ffff, 32'hffff_ffff, "R5 add");
      issue(st(4, 4) | alu(3, 3, 2), 1, 32'hffff_fff9, 32'hffff_fff9, "R5 sub");
      issue(st(1, 4) | alu(4, 3, 2), 1, 32'h3, 32'h0, "R5 and");
      issue(st(1, 4) | alu(5, 3, 3), 1, 32'h3, 32'hffff_ffff, "R5 or");
      issue(st(1, 4) | alu(7, 1, 2), 1, 32'h3, 32'h0, "R5 xor");
      issue(st(1, 4) | alu(6, 1, 2), 1, 32'h3, 32'h1, "R5 eq");
      issue(st(1, 4) | alu(8, 3, 1), 1, 32'h3, 32'h0, "R5 ne");
      issue(st(1, 4) | alu(8, 1, 3), 1, 32'h3, 32'h1, "R5 lt signed");
      // R6 PC operand goes to tgt, res unchanged
      issue(st(1, 4) | alu(1, 9, 3), 1, 32'h3, 32'h0, "R5 lt false");
      p18 = pc;
      issue(st(5, 4), 1, p18 - 32'h4, 32'h0, "R6 tgt/res");
      // R9 R10 copy and next-sequential
      issue(cp(0, 5) | SQ, 0, 0, 0, "");
      p20 = pc;
      issue(cp(1, 1) | st(7, 8), 1, p18 - 32'h4, 32'h0, "R9 cpa, cpb old");
      issue(st(6, 8), 1, p20 + 32'h8, 32'h3, "R9 R10 nxt/cpb");
      // R11 hold across idle words
      issue(64'h0, 0, 0, 0, "");
      issue(64'h0, 0, 0, 0, "");
      issue(st(3, 2), 1, 32'hffff_fffc, 32'h3, "R11 hold");
      // R3 write from sxt then read back
      issue(wr(7, 3), 0, 0, 0, "");
      issue(rdA(7), 0, 0, 0, "");
      issue(st(0, 0), 1, 32'hffff_fffc, 32'hffff_fffc, "R3 write from sxt");
      issue(64'h0, 0, 0, 0, "");
      issue(64'h0, 0, 0, 0, "");
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule